// File: doc/BRIEF.md
# Flash Page Program Buffer

This block gathers the data bytes of one page-program command for a serial flash array and commits them once the command is closed. A start pulse latches the target address: the upper bits select the page, and the low eight bits give the byte index where loading begins. Each byte strobed in is placed at the current index, and the index then steps forward. It wraps inside the page and never moves on to the next page, so an overlong stream leaves only its final 256 bytes in the buffer.

When the command-complete pulse arrives, a permit input from the controller decides whether the stored data is committed. If it is, the block holds busy for a fixed number of clock cycles. During that window it walks the whole page through a single-port RAM interface. For each byte it reads the current array value and writes back the AND of that value with the buffered byte. Bytes that were never loaded are skipped entirely. On the last busy cycle the block pulses a signal that tells the controller to clear its write-enable latch.

Top module: `flash_page_prog`

## Requirements
- R1: After reset busy_o, wel_clr_o, ram_re_o and ram_we_o are all 0.
- R2: A byte loaded k positions after the start is programmed at address {addr_i[ADDR_W-1:8], addr_i[7:0]+k} (the index wraps modulo 256).
- R3: When more than 256 bytes are loaded, only the last 256 are programmed, and each byte index holds the most recent byte loaded there.
- R4: Array bytes of the page whose index was never loaded receive no write and keep their value.
- R5: Each programmed byte becomes old_byte AND loaded_byte, so bits can only go from 1 to 0.
- R6: No RAM write happens before cmd_done_i closes the command.
- R7: After an accepted cmd_done_i, busy_o is high for exactly PROG_CYCLES consecutive cycles, starting in the next cycle. wel_clr_o pulses once, in the last busy cycle.
- R8: A cmd_done_i with permit_i low, or with no byte loaded, starts no busy period and no write.
- R9: start_i, data_valid_i and cmd_done_i are ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a command and latches addr_i |
| addr_i | input | ADDR_W | Start address: page plus byte index |
| data_valid_i | input | 1 | Strobe for data_i |
| data_i | input | 8 | Data byte |
| cmd_done_i | input | 1 | Command closed (chip select released) |
| permit_i | input | 1 | Controller allows programming, sampled with cmd_done_i |
| busy_o | output | 1 | Program cycle in progress |
| wel_clr_o | output | 1 | One-cycle pulse at the end of the cycle |
| ram_addr_o | output | ADDR_W | Array address |
| ram_re_o | output | 1 | Array read; data is returned one cycle later |
| ram_we_o | output | 1 | Array write |
| ram_wdata_o | output | 8 | Array write data |
| ram_rdata_i | input | 8 | Array read data |

## Verification
The bench builds the block with ADDR_W=10, which gives a 1 KiB array of four pages that a bench memory can model and compare in full after every command. PROG_CYCLES=600 is just above the 512-cycle page walk, so each busy window can be counted exactly while staying short. Start indexes near the page end, streams longer than a page, empty and refused commands, and traffic sent during busy all fit well inside the cycle budget.

// File: rtl/flash_pp_pkg.sv
package flash_pp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RD,
    ST_WR,
    ST_HOLD
  } pp_state_e;
endpackage

// File: rtl/fpp_store.sv
module fpp_store #(
  parameter int PAGE_BYTES = 256,
  localparam int IDX_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic             wr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o,
  output logic             rd_mask_o,
  output logic             any_o
);
  logic [IDX_W-1:0] wr_idx_q;
  logic [7:0]       byte_q [PAGE_BYTES];
  logic             mask_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wr_idx_q <= '0;
    else if (clr_i) wr_idx_q <= start_idx_i;
    else if (wr_i)  wr_idx_q <= wr_idx_q + 1'b1;  // wraps inside the page
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_i && !clr_i && wr_idx_q == IDX_W'(g)) byte_q[g] <= wr_data_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              mask_q[g] <= 1'b0;
      else if (clr_i)                           mask_q[g] <= 1'b0;
      else if (wr_i && wr_idx_q == IDX_W'(g))   mask_q[g] <= 1'b1;
    end
  end

  always_comb begin
    any_o = 1'b0;
    for (int i = 0; i < PAGE_BYTES; i++) any_o = any_o | mask_q[i];
  end

  assign rd_byte_o = byte_q[rd_idx_i];
  assign rd_mask_o = mask_q[rd_idx_i];

  // R3
  wr_mark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i) |=> mask_q[$past(wr_idx_q)]);
endmodule

// File: rtl/fpp_timer.sv
module fpp_timer #(
  parameter int PROG_CYCLES = 1024,
  localparam int CNT_W = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PROG_CYCLES - 1);
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i && !busy_q) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && cnt_q == LAST;

  // R7
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));
endmodule

// File: rtl/flash_page_prog.sv
module flash_page_prog
  import flash_pp_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_BYTES  = 256,
  parameter int PROG_CYCLES = 1024,
  localparam int IDX_W = $clog2(PAGE_BYTES),
  localparam int PG_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              data_valid_i,
  input  logic [7:0]        data_i,
  input  logic              cmd_done_i,
  input  logic              permit_i,
  output logic              busy_o,
  output logic              wel_clr_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic              ram_re_o,
  output logic              ram_we_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i
);
  pp_state_e        state_q, state_d;
  logic [PG_W-1:0]  page_q;
  logic [IDX_W-1:0] widx_q;
  logic             st_clr, st_wr, st_any, st_mask, tmr_go, tmr_done;
  logic [7:0]       st_byte;

  // A command is opened only from idle or load; cmd_done wins over a same-cycle byte
  assign st_clr = start_i && (state_q == ST_IDLE || state_q == ST_LOAD);
  assign st_wr  = state_q == ST_LOAD && data_valid_i && !cmd_done_i && !start_i;
  assign tmr_go = state_q == ST_LOAD && cmd_done_i && !start_i && permit_i && st_any;

  fpp_store #(.PAGE_BYTES(PAGE_BYTES)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (st_clr),
    .start_idx_i (addr_i[IDX_W-1:0]),
    .wr_i        (st_wr),
    .wr_data_i   (data_i),
    .rd_idx_i    (widx_q),
    .rd_byte_o   (st_byte),
    .rd_mask_o   (st_mask),
    .any_o       (st_any)
  );

  fpp_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_go),
    .busy_o  (busy_o),
    .done_o  (tmr_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_LOAD;
      ST_LOAD: begin
        if (start_i)         state_d = ST_LOAD;
        else if (tmr_go)     state_d = ST_RD;
        else if (cmd_done_i) state_d = ST_IDLE;
      end
      ST_RD:   state_d = ST_WR;
      ST_WR:   state_d = (widx_q == IDX_W'(PAGE_BYTES - 1)) ? ST_HOLD : ST_RD;
      ST_HOLD: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      page_q  <= '0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      if (st_clr) page_q <= addr_i[ADDR_W-1:IDX_W];
      if (tmr_go) widx_q <= '0;
      else if (state_q == ST_WR) widx_q <= widx_q + 1'b1;
    end
  end

  assign ram_addr_o  = {page_q, widx_q};
  assign ram_re_o    = state_q == ST_RD;
  assign ram_we_o    = state_q == ST_WR && st_mask;
  assign ram_wdata_o = ram_rdata_i & st_byte;  // program only clears bits
  assign wel_clr_o   = tmr_done;

  // R5
  clear_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_we_o |-> (ram_wdata_o & ~ram_rdata_i) == 8'h00);
  // R6
  no_idle_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ram_we_o);
  // R8
  permit_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(permit_i) && $past(cmd_done_i));
  // R9
  busy_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !st_wr && !st_clr);
endmodule

// File: tb/sim_flash_page_prog.sv
module sim_flash_page_prog;
  localparam int AW = 10;
  localparam int PC = 600;

  typedef struct packed {
    logic [9:0]  addr;
    logic [9:0]  n;
    logic [7:0]  base;
    logic        permit;
    logic [9:0]  exp_wr;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{10'h010, 10'd16,  8'h3C, 1'b1, 10'd16},   // R2 R4 mid-page
    '{10'h1F0, 10'd32,  8'h91, 1'b1, 10'd32},   // R2 wrap inside page
    '{10'h205, 10'd300, 8'h5A, 1'b1, 10'd256},  // R3 overlong stream
    '{10'h300, 10'd8,   8'h00, 1'b0, 10'd0},    // R8 refused
    '{10'h3FF, 10'd1,   8'h0F, 1'b1, 10'd1},    // R2 last byte
    '{10'h080, 10'd256, 8'hC3, 1'b1, 10'd256},  // R5 full page over prior data
    '{10'h100, 10'd0,   8'h00, 1'b1, 10'd0}     // R8 empty command
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, dv = 1'b0, done = 1'b0, permit = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic busy, wel, re, we;
  logic [AW-1:0] raddr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem [1 << AW];
  logic [7:0] shadow [1 << AW];
  int wr_cnt = 0, wel_cnt = 0, tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_page_prog #(.ADDR_W(AW), .PAGE_BYTES(256), .PROG_CYCLES(PC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .addr_i(addr),
    .data_valid_i(dv), .data_i(data), .cmd_done_i(done), .permit_i(permit),
    .busy_o(busy), .wel_clr_o(wel), .ram_addr_o(raddr), .ram_re_o(re),
    .ram_we_o(we), .ram_wdata_o(wdata), .ram_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      mem[raddr] <= wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (re) rdata <= mem[raddr];
    if (wel) wel_cnt <= wel_cnt + 1;
  end

  function automatic logic [7:0] dat(input logic [7:0] b, input int i);
    return b ^ 8'(i * 29) ^ 8'(i >> 2);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_mem(input string req);
    int bad = 0;
    for (int a = 0; a < (1 << AW); a++) begin
      if (mem[a] !== shadow[a]) begin
        if (bad == 0)
          $display("FAIL %s: addr %0h actual %02h expected %02h", req, a, mem[a], shadow[a]);
        bad++;
      end
    end
    tests++;
    if (bad != 0) fails++;
  endtask

  // Loads n bytes, closes the command and waits for the busy window to end
  task automatic run_op(input logic [9:0] a, input int n, input logic [7:0] b,
                        input logic p, output int pre_wr, output int wr_d,
                        output int bcyc, output int wel_d);
    int w0 = wr_cnt, l0 = wel_cnt;
    logic [7:0] lb [256];
    bit lm [256];
    for (int i = 0; i < 256; i++) lm[i] = 0;
    start = 1; addr = a; @(negedge clk); start = 0;
    for (int i = 0; i < n; i++) begin
      dv = 1; data = dat(b, i);
      lb[8'(a[7:0] + 8'(i))] = dat(b, i);
      lm[8'(a[7:0] + 8'(i))] = 1;
      @(negedge clk);
    end
    dv = 0;
    pre_wr = wr_cnt - w0;
    permit = p; done = 1; @(negedge clk); done = 0; permit = 0;
    bcyc = 0;
    while (busy && bcyc < 5000) begin
      bcyc++;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
    wr_d = wr_cnt - w0;
    wel_d = wel_cnt - l0;
    if (p && n > 0)
      for (int i = 0; i < 256; i++)
        if (lm[i]) shadow[{a[9:8], 8'(i)}] = shadow[{a[9:8], 8'(i)}] & lb[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pre_wr, wr_d, bcyc, wel_d;
    for (int a = 0; a < (1 << AW); a++) begin
      mem[a] = 8'(a * 7) ^ 8'hA5 ^ 8'(a >> 3);
      shadow[a] = mem[a];
    end
    rdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", int'(busy), 0);
    chk("R1 wel", int'(wel), 0);
    chk("R1 ram_we", int'(we), 0);
    chk("R1 ram_re", int'(re), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < 7; v++) begin
      run_op(VECS[v].addr, int'(VECS[v].n), VECS[v].base, VECS[v].permit,
             pre_wr, wr_d, bcyc, wel_d);
      chk("R6 no write before close", pre_wr, 0);
      chk("R4 R8 write count", wr_d, int'(VECS[v].exp_wr));
      chk("R7 R8 busy cycles", bcyc, VECS[v].exp_wr != 0 ? PC : 0);
      chk("R7 wel pulses", wel_d, VECS[v].exp_wr != 0 ? 1 : 0);
      chk_mem("R2 R3 R4 R5 array contents");
    end

    // R9: traffic during busy is ignored
    begin
      int w0, l0, n2;
      start = 1; addr = 10'h140; @(negedge clk); start = 0;
      for (int i = 0; i < 4; i++) begin
        dv = 1; data = dat(8'h77, i); @(negedge clk);
      end
      dv = 0;
      w0 = wr_cnt; l0 = wel_cnt;
      permit = 1; done = 1; @(negedge clk); done = 0; permit = 0;
      repeat (10) @(negedge clk);
      chk("R9 busy during test", int'(busy), 1);
      start = 1; addr = 10'h000; @(negedge clk); start = 0;
      for (int i = 0; i < 5; i++) begin
        dv = 1; data = 8'h00; @(negedge clk);
      end
      dv = 0;
      permit = 1; done = 1; @(negedge clk); done = 0; permit = 0;
      n2 = 0;
      while (busy && n2 < 5000) begin n2++; @(negedge clk); end
      repeat (20) @(negedge clk);
      for (int i = 0; i < 4; i++)
        shadow[10'h140 + i] = shadow[10'h140 + i] & dat(8'h77, i);
      chk("R9 no second busy", int'(busy), 0);
      chk("R9 write count", wr_cnt - w0, 4);
      chk("R9 single wel", wel_cnt - l0, 1);
      chk_mem("R9 array contents");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule